// File: doc/BRIEF.md
# AES Column Transform with Predicted-Code Error Correction

This block takes one four-byte column of the AES state and produces the column that results from byte substitution followed by the column mixing step. It does not perform row shifting, round-key addition or key expansion. The column mixing step multiplies the column by the fixed AES polynomial. Byte substitution uses the standard AES S-box. The block computes the S-box as a field inverse followed by the affine map, so it stores no table.

The block also carries a second path beside the datapath. From the input bytes alone, it predicts a 4-bit check code for each output byte. The prediction uses code tables of S(a), {02}·S(a) and {03}·S(a). The check code is linear, so the prediction for a row is the XOR of the table codes of the four input bytes, each taken with the coefficient that row applies to it. After the mixing step, the block recomputes the code of each byte. The difference from the prediction (the syndrome) points to a single flipped bit, and the block inverts that bit before the column is registered. A radiation upset inside the transform is therefore removed rather than only reported.

The block has one register stage. A column presented with the input strobe appears, corrected, on the next clock together with a per-row flag that shows which bytes needed attention.

Top module: `aes_pp_column`

## Requirements
- R1: With no upset, `column_out` equals the AES mixing step applied to the S-box image of the input column. Row r of the column is bits [8r+7:8r] on both buses, so row 0 is bits 7:0. Output row r is 2·S(a_r) ⊕ 3·S(a_{r+1}) ⊕ S(a_{r+2}) ⊕ S(a_{r+3}), with indices taken modulo 4.
- R2: The substitution is the AES S-box. For example, 0x00 maps to 0x63 and 0x53 maps to 0xED. An all-0x00 column therefore yields 0x63636363, and an all-0x53 column yields 0xEDEDEDED.
- R3: `valid_out` is `valid_in` delayed by exactly one rising clock edge. The result for the accepted column is on `column_out` in that same cycle.
- R4: While `valid_in` is low, `column_out` keeps its last value whatever `column_in` carries. In that state `err_flags` is 0 and `valid_out` falls.
- R5: While `rst_n` is low, `column_out`, `err_flags` and `valid_out` are all 0.
- R6: The check code c[3:0] of a byte b is formed as follows:
  - c3 = b7⊕b6⊕b4⊕b3⊕b1
  - c2 = b7⊕b5⊕b4⊕b2⊕b1
  - c1 = b6⊕b5⊕b4⊕b0
  - c0 = b3⊕b2⊕b1⊕b0

  The syndrome is the predicted code XOR the recomputed code. Syndrome values 1100, 1010, 0110, 1110, 1001, 0101, 1101 and 0011 select bits 7, 6, 5, 4, 3, 2, 1 and 0 respectively.
- R7: A single-bit upset on any of the 32 bits at the output of the mixing step is corrected, so `column_out` equals the fault-free result. The flag `err_flags[r]` of the affected row r is set.
- R8: With no upset, `err_flags` is 0 for every accepted column.
- R9: If a byte's syndrome is nonzero but matches none of the eight listed values (for example, bits 4 and 3 both flipped), that byte is released as computed without correction, and its flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Column strobe; `column_in` is taken on this edge |
| column_in | input | 32 | Input column, row r in bits [8r+7:8r] |
| column_out | output | 32 | Corrected, transformed column |
| valid_out | output | 1 | `column_out` holds a new result |
| err_flags | output | 4 | Per-row flag: nonzero syndrome seen on that byte |

## Verification
The assertions take for granted that `valid_in` is held low throughout reset. They also assume that any upset strikes only the mixing-step output, never the prediction path, so a clean syndrome means the raw byte can be passed through as is. The bench keeps the strobe low during reset and injects upsets only by overriding the internal mixed column for one cycle. Every injected mask has at most two bits per byte, and the two-bit mask is chosen so that its syndrome selects no bit.

// File: rtl/aes_pp_pkg.sv
package aes_pp_pkg;

    localparam int BYTE_W = 8;
    localparam int CODE_W = 4;
    localparam int ROWS   = 4;
    localparam int COL_W  = ROWS * BYTE_W;
    localparam int PRED_W = ROWS * CODE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic             valid;
        logic [COL_W-1:0] col;
        logic [ROWS-1:0]  err;
    } stage_t;

    // multiply by {02} in GF(2^8) modulo x^8+x^4+x^3+x+1
    function automatic byte_t gf_dbl(input byte_t x);
        return {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t x, input byte_t y);
        byte_t acc;
        byte_t p;
        acc = '0;
        p   = x;
        for (int i = 0; i < BYTE_W; i++) begin
            if (y[i]) acc = acc ^ p;
            p = gf_dbl(p);
        end
        return acc;
    endfunction

    // x^254 is the multiplicative inverse (and maps 0 to 0)
    function automatic byte_t gf_inv(input byte_t x);
        byte_t r;
        byte_t p;
        r = 8'h01;
        p = x;
        for (int i = 0; i < BYTE_W; i++) begin
            if (i != 0) r = gf_mul(r, p);
            p = gf_mul(p, p);
        end
        return r;
    endfunction

    function automatic byte_t sub_byte(input byte_t x);
        byte_t v;
        v = gf_inv(x);
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
                 ^ {v[3:0], v[7:4]} ^ 8'h63;
    endfunction

    function automatic code_t ham_code(input byte_t b);
        code_t c;
        c[3] = b[7] ^ b[6] ^ b[4] ^ b[3] ^ b[1];
        c[2] = b[7] ^ b[5] ^ b[4] ^ b[2] ^ b[1];
        c[1] = b[6] ^ b[5] ^ b[4] ^ b[0];
        c[0] = b[3] ^ b[2] ^ b[1] ^ b[0];
        return c;
    endfunction

    // code tables of S(a), {02}S(a), {03}S(a)
    function automatic code_t tab_h1(input byte_t a);
        return ham_code(sub_byte(a));
    endfunction

    function automatic code_t tab_h2(input byte_t a);
        return ham_code(gf_dbl(sub_byte(a)));
    endfunction

    function automatic code_t tab_h3(input byte_t a);
        byte_t s;
        s = sub_byte(a);
        return ham_code(gf_dbl(s) ^ s);
    endfunction

    // syndrome to flip mask; zero when no single bit matches
    function automatic byte_t syn_mask(input code_t s);
        byte_t m;
        case (s)
            4'b1100: m = 8'h80;
            4'b1010: m = 8'h40;
            4'b0110: m = 8'h20;
            4'b1110: m = 8'h10;
            4'b1001: m = 8'h08;
            4'b0101: m = 8'h04;
            4'b1101: m = 8'h02;
            4'b0011: m = 8'h01;
            default: m = 8'h00;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/aes_pp_mix.sv
module aes_pp_mix
    import aes_pp_pkg::*;
(
    input  logic [COL_W-1:0] col_in,
    output logic [COL_W-1:0] col_mixed
);
    byte_t sb [ROWS];
    byte_t s2 [ROWS];
    byte_t s3 [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_sub
        always_comb begin
            sb[r] = sub_byte(col_in[r*BYTE_W +: BYTE_W]);
            s2[r] = gf_dbl(sb[r]);
            s3[r] = s2[r] ^ sb[r];
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        localparam int N1 = (r + 1) % ROWS;
        localparam int N2 = (r + 2) % ROWS;
        localparam int N3 = (r + 3) % ROWS;
        assign col_mixed[r*BYTE_W +: BYTE_W] = s2[r] ^ s3[N1] ^ sb[N2] ^ sb[N3];
    end
endmodule

// File: rtl/aes_pp_predict.sv
module aes_pp_predict
    import aes_pp_pkg::*;
(
    input  logic [COL_W-1:0]  col_in,
    output logic [PRED_W-1:0] pred
);
    code_t h1 [ROWS];
    code_t h2 [ROWS];
    code_t h3 [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_tab
        always_comb begin
            h1[r] = tab_h1(col_in[r*BYTE_W +: BYTE_W]);
            h2[r] = tab_h2(col_in[r*BYTE_W +: BYTE_W]);
            h3[r] = tab_h3(col_in[r*BYTE_W +: BYTE_W]);
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        localparam int N1 = (r + 1) % ROWS;
        localparam int N2 = (r + 2) % ROWS;
        localparam int N3 = (r + 3) % ROWS;
        assign pred[r*CODE_W +: CODE_W] = h2[r] ^ h3[N1] ^ h1[N2] ^ h1[N3];
    end
endmodule

// File: rtl/aes_pp_fix.sv
module aes_pp_fix
    import aes_pp_pkg::*;
(
    input  logic [COL_W-1:0]  col_raw,
    input  logic [PRED_W-1:0] pred,
    output logic [COL_W-1:0]  col_fixed,
    output logic [ROWS-1:0]   row_err
);
    for (genvar r = 0; r < ROWS; r++) begin : g_lane
        byte_t raw_b;
        code_t syn;
        always_comb begin
            raw_b = col_raw[r*BYTE_W +: BYTE_W];
            syn   = pred[r*CODE_W +: CODE_W] ^ ham_code(raw_b);
            col_fixed[r*BYTE_W +: BYTE_W] = raw_b ^ syn_mask(syn);
            row_err[r] = |syn;
        end
    end
endmodule

// File: rtl/aes_pp_column.sv
module aes_pp_column
    import aes_pp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_in,
    input  logic [COL_W-1:0] column_in,
    output logic [COL_W-1:0] column_out,
    output logic             valid_out,
    output logic [ROWS-1:0]  err_flags
);
    logic [COL_W-1:0]  mix_raw;
    logic [PRED_W-1:0] pred_code;
    logic [COL_W-1:0]  fixed_col;
    logic [ROWS-1:0]   fix_err;

    stage_t st_d;
    stage_t st_q;

    aes_pp_mix u_mix (
        .col_in    (column_in),
        .col_mixed (mix_raw)
    );

    aes_pp_predict u_pred (
        .col_in (column_in),
        .pred   (pred_code)
    );

    aes_pp_fix u_fix (
        .col_raw   (mix_raw),
        .pred      (pred_code),
        .col_fixed (fixed_col),
        .row_err   (fix_err)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = valid_in;
        st_d.err   = '0;
        if (valid_in) begin
            st_d.col = fixed_col;
            st_d.err = fix_err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign column_out = st_q.col;
    assign valid_out  = st_q.valid;
    assign err_flags  = st_q.err;

    // R3: strobe lags by one edge
    p_valid_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);
    p_valid_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);
    // R4: idle cycles leave the column untouched
    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(column_out));
    // R4: flags only accompany a fresh result
    p_flags_need_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flags != '0) |-> valid_out);
    // R8: a clean syndrome releases the mixed column unchanged
    p_clean_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && fix_err == '0) |=> column_out == $past(mix_raw));
endmodule

// File: tb/sim_aes_pp_column.sv
`timescale 1ns/1ps
module sim_aes_pp_column;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [31:0] column_in = '0;
    logic [31:0] column_out;
    logic        valid_out;
    logic [3:0]  err_flags;
    logic [31:0] inj;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    aes_pp_column u0 (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .column_in(column_in),
        .column_out(column_out), .valid_out(valid_out), .err_flags(err_flags)
    );

    typedef struct packed {
        logic [31:0] col;
        logic [31:0] flip;
        logic [3:0]  err;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{32'h00000000, 32'h00000000, 4'h0},
        '{32'h01010101, 32'h00000000, 4'h0},
        '{32'hd4bf5d30, 32'h00000000, 4'h0},
        '{32'h53000000, 32'h00000000, 4'h0},
        '{32'h12345678, 32'h00000001, 4'h1},
        '{32'h89abcdef, 32'h00008000, 4'h2},
        '{32'hffffffff, 32'h00100000, 4'h4},
        '{32'ha5c3e17f, 32'h40000000, 4'h8},
        '{32'hdeadbeef, 32'h01000100, 4'ha},
        '{32'hcafef00d, 32'h00000018, 4'h1},
        '{32'h0f1e2d3c, 32'h80402010, 4'hf}
    };

    // independent reference model
    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] m_sbox(input logic [7:0] a);
        logic [7:0] inv;
        logic [7:0] s;
        inv = 8'h00;
        for (int b = 1; b < 256; b++) if (m_mul(a, 8'(b)) == 8'h01) inv = 8'(b);
        for (int i = 0; i < 8; i++)
            s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                 ^ inv[(i+7)%8] ^ (8'h63 >> i);
        return s;
    endfunction

    function automatic logic [31:0] m_col(input logic [31:0] c);
        logic [7:0] s [4];
        logic [31:0] o;
        for (int r = 0; r < 4; r++) s[r] = m_sbox(c[8*r +: 8]);
        for (int r = 0; r < 4; r++)
            o[8*r +: 8] = m_mul(s[r], 8'h02) ^ m_mul(s[(r+1)%4], 8'h03)
                        ^ s[(r+2)%4] ^ s[(r+3)%4];
        return o;
    endfunction

    function automatic logic [31:0] m_expect(input logic [31:0] g, input logic [31:0] f);
        logic [31:0] o;
        for (int r = 0; r < 4; r++)
            o[8*r +: 8] = ($countones(f[8*r +: 8]) <= 1) ? g[8*r +: 8]
                                                         : g[8*r +: 8] ^ f[8*r +: 8];
        return o;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_col(input logic [31:0] c, input logic [31:0] f);
        @(negedge clk);
        column_in = c;
        valid_in  = 1'b1;
        if (f != 0) begin
            inj = m_col(c) ^ f;
            force u0.mix_raw = inj;
        end
        @(negedge clk);
        valid_in = 1'b0;
        if (f != 0) release u0.mix_raw;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R3 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] g;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        chk("R5 column_out in reset", column_out, 32'h0);
        chk("R5 valid/err in reset", {27'h0, valid_out, err_flags}, 32'h0);
        rst_n = 1'b1;

        // R2 known answers
        run_col(32'h00000000, 32'h0);
        chk("R2 all-zero column", column_out, 32'h63636363);
        run_col(32'h53535353, 32'h0);
        chk("R2 all-0x53 column", column_out, 32'hedededed);
        chk("R3 valid_out after strobe", {31'h0, valid_out}, 32'h1);

        // table walk: R1, R7, R8, R9
        for (int i = 0; i < NV; i++) begin
            run_col(VECS[i].col, VECS[i].flip);
            g = m_col(VECS[i].col);
            if (VECS[i].flip == 0) begin
                chk("R1 transform", column_out, g);
                chk("R8 clean flags", {28'h0, err_flags}, 32'h0);
            end else begin
                chk("R7 R9 released column", column_out, m_expect(g, VECS[i].flip));
                chk("R7 R9 flags", {28'h0, err_flags}, {28'h0, VECS[i].err});
            end
        end

        // R6 R7 every bit position
        for (int k = 0; k < 32; k++) begin
            run_col(32'h3c5a9617 ^ (32'h01010101 * 32'(k)), 32'h1 << k);
            g = m_col(32'h3c5a9617 ^ (32'h01010101 * 32'(k)));
            chk("R7 single-bit fix column", column_out, g);
            chk("R6 flag row", {28'h0, err_flags}, 32'h1 << (k / 8));
        end

        // R4 hold while idle
        run_col(32'h7700ff11, 32'h0);
        held = column_out;
        @(negedge clk);
        column_in = 32'hffffffff;
        @(negedge clk);
        chk("R4 column held", column_out, held);
        chk("R4 flags and valid low", {27'h0, valid_out, err_flags}, 32'h0);
        chk("R3 valid_out falls", {31'h0, valid_out}, 32'h0);

        // R5 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R5 column_out after reset", column_out, 32'h0);
        rst_n = 1'b1;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule